// File: doc/BRIEF.md
# Dual-Register Multiplexer Logic Cell

This block is one cell of a programmable logic fabric. Two wide AND gates and four two-input AND gates steer a seven-way tree of two-to-one multiplexers. The tree drives two D flip-flops. Four of the cell's outputs are combinational taps on the tree and two are registered. One mapped function can therefore compute a wide product term, a multiplexed selection and a stored state in a single level of logic.

Both flip-flops share one clock, one asynchronous set and one asynchronous reset. The main register always stores the final tree output. The auxiliary register takes its data through a configuration multiplexer. That multiplexer picks either an internal tree node or a dedicated bypass pin, so the auxiliary flop can act as a plain pipeline register for an unrelated signal. The configuration select is static: it is written while the cell is held in reset and is not changed during operation. Register outputs never feed back into the tree.

Top module: `logic_cell`

## Requirements
- R1: `y_wide` is 1 exactly when every bit of `in_a` is 1.
- R2: Three first-level muxes U, V and W each output data bit 1 of their pair (`mu_d`, `mv_d`, `mw_d`) when both bits of their select pair (`mu_s`, `mv_s`, `mw_s`) are 1, and data bit 0 otherwise. `y_lo` equals V when `y_wide` is 1, and U otherwise.
- R3: `y_hi` equals the AND of both bits of `gt_in` when `y_wide` is 1, and mux W otherwise.
- R4: `y_out` equals `y_hi` when every bit of `in_f` is 1, and `y_lo` otherwise.
- R5: On each rising `clk` edge with neither `clr` nor `pst` active, `q_main` takes the value of `y_out`.
- R6: On each such edge, `q_aux` takes `y_hi` when `cfg_bypass` is 0, and `byp_d` when `cfg_bypass` is 1.
- R7: Raising `clr` clears both `q_main` and `q_aux` at once, without a clock edge.
- R8: Raising `pst` while `clr` is low sets both registers to 1 at once, without a clock edge.
- R9: While `clr` and `pst` are both high, both registers read 0.
- R10: The combinational outputs depend only on the input pins, never on the register state. They keep their values across a clock edge that changes the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both flip-flops |
| clr | input | 1 | Asynchronous clear, active high, wins over `pst` |
| pst | input | 1 | Asynchronous preset, active high |
| cfg_bypass | input | 1 | Static select for the auxiliary register's data source |
| in_a | input | WIDE_N | Inputs of the first wide AND gate |
| in_f | input | WIDE_N | Inputs of the second wide AND gate |
| mu_d | input | 2 | Data pair of first-level mux U |
| mu_s | input | 2 | Select AND pair of mux U |
| mv_d | input | 2 | Data pair of first-level mux V |
| mv_s | input | 2 | Select AND pair of mux V |
| mw_d | input | 2 | Data pair of first-level mux W |
| mw_s | input | 2 | Select AND pair of mux W |
| gt_in | input | 2 | Two-input AND gate feeding the upper second-level mux |
| byp_d | input | 1 | Direct data input for the auxiliary register |
| y_wide | output | 1 | Output of the first wide AND gate |
| y_lo | output | 1 | Lower second-level mux output |
| y_hi | output | 1 | Upper second-level mux output |
| y_out | output | 1 | Final tree output |
| q_main | output | 1 | Main registered output |
| q_aux | output | 1 | Auxiliary registered output |

## Verification
The bound checker watches the register side on every clock. It checks that `q_main` and `q_aux` hold what their data paths carried at the previous edge, with the auxiliary source chosen by `cfg_bypass`. It also checks the clear, preset and clear-over-preset values whenever those controls are high at a falling edge. The tree equations, the independence of the tree from the register state, and the immediate effect of `clr` and `pst` between clock edges are shown only by the bench. The bench compares random and forced-all-ones gate patterns against its own model under both configuration settings, and it probes the flops in the middle of a cycle.

// File: rtl/logic_cell.sv
module logic_cell #(
  parameter int WIDE_N = 6
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              pst,
  input  logic              cfg_bypass,
  input  logic [WIDE_N-1:0] in_a,
  input  logic [WIDE_N-1:0] in_f,
  input  logic [1:0]        mu_d,
  input  logic [1:0]        mu_s,
  input  logic [1:0]        mv_d,
  input  logic [1:0]        mv_s,
  input  logic [1:0]        mw_d,
  input  logic [1:0]        mw_s,
  input  logic [1:0]        gt_in,
  input  logic              byp_d,
  output logic              y_wide,
  output logic              y_lo,
  output logic              y_hi,
  output logic              y_out,
  output logic              q_main,
  output logic              q_aux
);

  logic wide_f, u_o, v_o, w_o, gate_o, aux_d;

  assign y_wide = &in_a;
  assign wide_f = &in_f;

  assign u_o    = (&mu_s) ? mu_d[1] : mu_d[0];
  assign v_o    = (&mv_s) ? mv_d[1] : mv_d[0];
  assign w_o    = (&mw_s) ? mw_d[1] : mw_d[0];
  assign gate_o = &gt_in;

  assign y_lo  = y_wide ? v_o : u_o;
  assign y_hi  = y_wide ? gate_o : w_o;
  assign y_out = wide_f ? y_hi : y_lo;

  assign aux_d = cfg_bypass ? byp_d : y_hi;

  always_ff @(posedge clk or posedge clr or posedge pst) begin
    if (clr) begin
      q_main <= 1'b0;
      q_aux  <= 1'b0;
    end else if (pst) begin
      q_main <= 1'b1;
      q_aux  <= 1'b1;
    end else begin
      q_main <= y_out;
      q_aux  <= aux_d;
    end
  end

endmodule

module logic_cell_chk #(
  parameter int WIDE_N = 6
) (
  input logic              clk,
  input logic              clr,
  input logic              pst,
  input logic              cfg_bypass,
  input logic [WIDE_N-1:0] in_a,
  input logic [WIDE_N-1:0] in_f,
  input logic              byp_d,
  input logic              y_hi,
  input logic              y_out,
  input logic              q_main,
  input logic              q_aux
);

  p_capture_r5: assert property (@(posedge clk) disable iff (clr || pst)
    (!clr && !pst) |=> (q_main == $past(y_out)));

  p_aux_src_r6: assert property (@(posedge clk) disable iff (clr || pst)
    (!clr && !pst) |=> (q_aux == $past(cfg_bypass ? byp_d : y_hi)));

  always @(negedge clk) begin
    if (clr) begin
      p_clear_r7_r9: assert (!q_main && !q_aux);
    end else if (pst) begin
      p_preset_r8: assert (q_main && q_aux);
    end
  end

endmodule

bind logic_cell logic_cell_chk #(.WIDE_N(WIDE_N)) u_chk (
  .clk(clk), .clr(clr), .pst(pst), .cfg_bypass(cfg_bypass),
  .in_a(in_a), .in_f(in_f), .byp_d(byp_d), .y_hi(y_hi),
  .y_out(y_out), .q_main(q_main), .q_aux(q_aux)
);

// File: tb/test_logic_cell.sv
module test_logic_cell;
  localparam int PERIOD = 10;
  localparam int W = 6;
  localparam int NVEC = 300;

  logic clk = 1'b0;
  logic clr = 1'b1, pst = 1'b0, cfg_bypass = 1'b0;
  logic [W-1:0] in_a = '0, in_f = '0;
  logic [1:0] mu_d = '0, mu_s = '0, mv_d = '0, mv_s = '0, mw_d = '0, mw_s = '0, gt_in = '0;
  logic byp_d = 1'b0;
  logic y_wide, y_lo, y_hi, y_out, q_main, q_aux;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic wide, lo, hi, out, qm, qa;
  } exp_t;
  exp_t exp_q[$];

  always #(PERIOD/2) clk = ~clk;

  logic_cell #(.WIDE_N(W)) i_logic_cell (
    .clk(clk), .clr(clr), .pst(pst), .cfg_bypass(cfg_bypass),
    .in_a(in_a), .in_f(in_f), .mu_d(mu_d), .mu_s(mu_s), .mv_d(mv_d), .mv_s(mv_s),
    .mw_d(mw_d), .mw_s(mw_s), .gt_in(gt_in), .byp_d(byp_d),
    .y_wide(y_wide), .y_lo(y_lo), .y_hi(y_hi), .y_out(y_out),
    .q_main(q_main), .q_aux(q_aux)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic exp_t model();
    exp_t e;
    logic u, v, w;
    u = (mu_s == 2'b11) ? mu_d[1] : mu_d[0];
    v = (mv_s == 2'b11) ? mv_d[1] : mv_d[0];
    w = (mw_s == 2'b11) ? mw_d[1] : mw_d[0];
    e.wide = (in_a == '1);
    e.lo   = e.wide ? v : u;
    e.hi   = e.wide ? (gt_in == 2'b11) : w;
    e.out  = (in_f == '1) ? e.hi : e.lo;
    e.qm   = e.out;
    e.qa   = cfg_bypass ? byp_d : e.hi;
    return e;
  endfunction

  task automatic drive_vec();
    @(negedge clk);
    in_a  = ($urandom % 3 == 0) ? '1 : W'($urandom);
    in_f  = ($urandom % 2 == 0) ? '1 : W'($urandom);
    mu_d  = 2'($urandom); mu_s = 2'($urandom);
    mv_d  = 2'($urandom); mv_s = 2'($urandom);
    mw_d  = 2'($urandom); mw_s = 2'($urandom);
    gt_in = 2'($urandom); byp_d = 1'($urandom);
    exp_q.push_back(model());
  endtask

  // monitor: samples 2 time units after the edge that consumes each item
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R1", y_wide, e.wide);
        chk("R2", y_lo, e.lo);
        chk("R3", y_hi, e.hi);
        chk("R4,R10", y_out, e.out);
        chk("R5", q_main, e.qm);
        chk("R6", q_aux, e.qa);
      end
    end
  end

  task automatic async_probe();
    @(negedge clk);
    #1 pst = 1'b1;
    #1 chk("R8 q_main", q_main, 1'b1);
       chk("R8 q_aux", q_aux, 1'b1);
    clr = 1'b1;
    #1 chk("R9 q_main", q_main, 1'b0);
       chk("R9 q_aux", q_aux, 1'b0);
    pst = 1'b0;
    @(posedge clk);
    #1 chk("R7 q_main", q_main, 1'b0);
       chk("R7 q_aux", q_aux, 1'b0);
    @(negedge clk);
    clr = 1'b0;
  endtask

  initial begin
    #(PERIOD*3 + 1);
    chk("R7 reset q_main", q_main, 1'b0);
    chk("R7 reset q_aux", q_aux, 1'b0);
    @(negedge clk);
    clr = 1'b0;
    for (int i = 0; i < NVEC; i++) drive_vec();
    repeat (3) @(negedge clk);
    async_probe();
    // mid-cycle clear from a set state
    drive_vec();
    in_f = '1; in_a = '1; gt_in = 2'b11;
    exp_q.pop_back();
    exp_q.push_back(model());
    repeat (3) @(negedge clk);
    #1 clr = 1'b1;
    #1 chk("R7 mid-cycle q_main", q_main, 1'b0);
       chk("R7 mid-cycle q_aux", q_aux, 1'b0);
    @(negedge clk);
    cfg_bypass = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    for (int i = 0; i < NVEC; i++) drive_vec();
    repeat (3) @(negedge clk);
    async_probe();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD*20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule